// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Engine

This block is the device end of a read port on a memory of 32-bit words. A 16-bit configuration register chooses how reads behave. In asynchronous mode, a strobed address returns one word. In burst mode, the engine waits a programmed number of clocks and then streams consecutive words, one per rising clock edge. A wait indicator marks the start-up latency and can be set to drop one cycle early, so the host can prepare for the first word.

The storage is a small register file. Its reset contents are computed from the address, and a plain write port can overwrite any word. The host writes the configuration register directly. An address strobe can arrive at any time: it abandons the current access and starts a new one with the configuration that is in force at that edge.

Top module: `burst_read_engine`

## Requirements
- R1: After reset the configuration register holds 0xBD8B, which selects asynchronous reads. `rd_valid`, `rd_wait` and `rd_data` are all 0 until the first strobe.
- R2: A write on `cfg_we` loads `cfg_wdata` into the configuration register at that clock edge. The new value applies to every strobe sampled at a later edge.
- R3: When `adr_valid` is sampled high at edge E and burst is enabled, the first word `mem[addr]` appears on `rd_data` with `rd_valid` high in the cycle after edge E+L. L = cfg[12:10] + 2, so L runs from 2 to 9. Bit 13 has no effect.
- R4: A burst delivers N words on consecutive cycles. N is set by cfg[2:0]: 001 gives 2 words, 010 gives 4 and 011 gives 8. Word k comes from address (addr+k) modulo the depth. After the burst, `rd_valid` returns to 0.
- R5: Burst is enabled only when bit 15 is 0, bit 7 is 1, bit 6 is 1 and cfg[2:0] is 001, 010 or 011. In every other case the engine reads asynchronously: `mem[addr]` is valid for exactly the one cycle after edge E, and `rd_wait` stays low.
- R6: With cfg[8] = 0, `rd_wait` is high for the L cycles after edge E.
- R7: With cfg[8] = 1, `rd_wait` is high for L-1 cycles after edge E, so it drops one cycle before the first word.
- R8: A strobe during a burst or its latency abandons that access at once. The new access then follows R3 to R7 from the new edge.
- R9: `rd_wait` and `rd_valid` are never both high. `rd_data` is 0 whenever `rd_valid` is low.
- R10: The mode, latency, length and wait timing are captured at the strobe edge. A configuration write during an access does not change that access.
- R11: After reset, word i holds ((i+1)*0x9E3779B9 mod 2^32) XOR 0x5A5AC3C3. A write on `mem_we` replaces word `mem_waddr` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 16 | Configuration write value |
| mem_we | input | 1 | Storage write enable |
| mem_waddr | input | ADDR_W | Storage write address |
| mem_wdata | input | DATA_W | Storage write data |
| adr_valid | input | 1 | Address strobe; starts a read |
| addr | input | ADDR_W | Start address, sampled with the strobe |
| rd_data | output | DATA_W | Read word, 0 when not valid |
| rd_valid | output | 1 | `rd_data` holds a word |
| rd_wait | output | 1 | Initial latency indicator |

## Verification
The hardest situation to reach from the ports is a strobe that arrives partway through a latency count or a burst, because the restart has to discard both the delay counter and the word counter. A configuration write that lands in the middle of an access is equally hard to reach. The random stimulus cuts a large share of its reads short at a random cycle and strobes a new address straight after. It also mixes fully random register values, which reach the reserved codes, with values forced into burst mode. Directed cases pin down the extremes: the minimum and maximum latency, the early wait mode, an address that wraps, and a configuration write during a burst.

// File: rtl/bre_pkg.sv
package bre_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_DATA  = 2'd2,
      ST_ASYNC = 2'd3
   } bre_state_e;

   localparam logic [15:0] CFG_DEFAULT = 16'hBD8B;

   localparam int F_MODE    = 15;
   localparam int F_LAT_LO  = 10;
   localparam int F_WAITPOS = 8;
   localparam int F_ORDER   = 7;
   localparam int F_EDGE    = 6;

   function automatic logic [31:0] bre_init_word(input int unsigned idx);
      logic [31:0] prod;
      prod = 32'(idx + 1) * 32'h9E3779B9;
      return prod ^ 32'h5A5AC3C3;
   endfunction

endpackage

// File: rtl/bre_cfg_reg.sv
module bre_cfg_reg
   import bre_pkg::*;
#(
   parameter logic [15:0] CFG_RESET = CFG_DEFAULT,
   parameter int          CNT_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [15:0]      wdata,
   output logic             burst_en,
   output logic [CNT_W-1:0] lat_clks,
   output logic [CNT_W-1:0] len_words,
   output logic             wait_early
);

   if (CNT_W < 4) begin : g_bad_cnt
      $error("bre_cfg_reg: CNT_W must hold values up to 9");
   end

   logic [15:0] cfg_q;
   logic [2:0]  len_code;
   logic        unused_cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= CFG_RESET;
      else if (we) cfg_q <= wdata;
   end

   assign len_code = cfg_q[2:0];

   always_comb begin
      case (len_code)
         3'd1:    len_words = CNT_W'(2);
         3'd2:    len_words = CNT_W'(4);
         3'd3:    len_words = CNT_W'(8);
         default: len_words = '0;
      endcase
   end

   assign lat_clks   = CNT_W'(cfg_q[F_LAT_LO +: 3]) + CNT_W'(2);
   assign wait_early = cfg_q[F_WAITPOS];
   assign burst_en   = !cfg_q[F_MODE] && cfg_q[F_ORDER] && cfg_q[F_EDGE]
                       && (len_words != '0);

   assign unused_cfg = ^{cfg_q[14], cfg_q[13], cfg_q[9], cfg_q[5:3]};

   a_r5_burst_needs_legal_bits: assert property (@(posedge clk) disable iff (!rst_n)
      burst_en |-> (cfg_q[7:6] == 2'b11 && !cfg_q[15]));
   a_r3_latency_range: assert property (@(posedge clk) disable iff (!rst_n)
      lat_clks >= CNT_W'(2) && lat_clks <= CNT_W'(9));

endmodule

// File: rtl/bre_store.sv
module bre_store
   import bre_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      localparam logic [DATA_W-1:0] INIT = DATA_W'(bre_init_word(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) words[i] <= INIT;
         else if (wr_en && wr_addr == ADDR_W'(i)) words[i] <= wr_data;
      end
   end

   assign rd_data = words[rd_addr];

endmodule

// File: rtl/bre_seq.sv
module bre_seq
   import bre_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [ADDR_W-1:0] addr,
   input  logic              burst_en,
   input  logic [CNT_W-1:0]  lat_clks,
   input  logic [CNT_W-1:0]  len_words,
   input  logic              wait_early,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_raddr,
   output logic [DATA_W-1:0] dout,
   output logic              dout_valid,
   output logic              wait_o
);

   bre_state_e        st_q;
   logic [CNT_W-1:0]  dly_q;
   logic [CNT_W-1:0]  left_q;
   logic [ADDR_W-1:0] ptr_q;
   logic              early_q;

   assign mem_raddr = adv ? addr : ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         dly_q   <= '0;
         left_q  <= '0;
         ptr_q   <= '0;
         early_q <= 1'b0;
         dout    <= '0;
      end else begin
         dout <= '0;
         if (adv) begin
            ptr_q   <= addr;
            early_q <= wait_early;
            if (burst_en) begin
               st_q   <= ST_DELAY;
               dly_q  <= lat_clks;
               left_q <= len_words - CNT_W'(1);
            end else begin
               st_q <= ST_ASYNC;
               dout <= mem_rdata;
            end
         end else begin
            case (st_q)
               ST_DELAY: begin
                  if (dly_q == CNT_W'(1)) begin
                     st_q  <= ST_DATA;
                     dout  <= mem_rdata;
                     ptr_q <= ptr_q + ADDR_W'(1);
                  end else begin
                     dly_q <= dly_q - CNT_W'(1);
                  end
               end
               ST_DATA: begin
                  if (left_q == '0) begin
                     st_q <= ST_IDLE;
                  end else begin
                     dout   <= mem_rdata;
                     ptr_q  <= ptr_q + ADDR_W'(1);
                     left_q <= left_q - CNT_W'(1);
                  end
               end
               ST_ASYNC: st_q <= ST_IDLE;
               default:  st_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign dout_valid = (st_q == ST_DATA) || (st_q == ST_ASYNC);
   assign wait_o     = (st_q == ST_DELAY) && !(early_q && dly_q == CNT_W'(1));

   a_r9_wait_valid_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(wait_o && dout_valid));
   a_r9_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_valid |-> dout == '0);
   a_r3_wait_follows_burst_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && burst_en) |=> (wait_o && !dout_valid));
   a_r5_async_single_word: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !burst_en) |=> (dout_valid && !wait_o));
   a_r8_strobe_restarts_pointer: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> ptr_q == $past(addr));
   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DATA) |-> left_q < CNT_W'(8));

endmodule

// File: rtl/burst_read_engine.sv
module burst_read_engine
   import bre_pkg::*;
#(
   parameter int          ADDR_W    = 6,
   parameter int          DATA_W    = 32,
   parameter logic [15:0] CFG_RESET = CFG_DEFAULT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [15:0]       cfg_wdata,
   input  logic              mem_we,
   input  logic [ADDR_W-1:0] mem_waddr,
   input  logic [DATA_W-1:0] mem_wdata,
   input  logic              adr_valid,
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              rd_wait
);

   localparam int CNT_W = 4;

   if (ADDR_W < 3 || ADDR_W > 10) begin : g_bad_addr
      $error("burst_read_engine: ADDR_W out of range 3..10");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("burst_read_engine: DATA_W must be at least 8");
   end

   logic              burst_en;
   logic [CNT_W-1:0]  lat_clks;
   logic [CNT_W-1:0]  len_words;
   logic              wait_early;
   logic [ADDR_W-1:0] mem_raddr;
   logic [DATA_W-1:0] mem_rdata;

   bre_cfg_reg #(.CFG_RESET(CFG_RESET), .CNT_W(CNT_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .wdata      (cfg_wdata),
      .burst_en   (burst_en),
      .lat_clks   (lat_clks),
      .len_words  (len_words),
      .wait_early (wait_early)
   );

   bre_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mem_we),
      .wr_addr (mem_waddr),
      .wr_data (mem_wdata),
      .rd_addr (mem_raddr),
      .rd_data (mem_rdata)
   );

   bre_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (adr_valid),
      .addr       (addr),
      .burst_en   (burst_en),
      .lat_clks   (lat_clks),
      .len_words  (len_words),
      .wait_early (wait_early),
      .mem_rdata  (mem_rdata),
      .mem_raddr  (mem_raddr),
      .dout       (rd_data),
      .dout_valid (rd_valid),
      .wait_o     (rd_wait)
   );

endmodule

// File: tb/burst_read_engine_bench.sv
`timescale 1ns/1ps
module burst_read_engine_bench;

   localparam int AW    = 6;
   localparam int DW    = 32;
   localparam int DEPTH = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [15:0]   cfg_wdata = '0;
   logic          mem_we = 1'b0;
   logic [AW-1:0] mem_waddr = '0;
   logic [DW-1:0] mem_wdata = '0;
   logic          adr_valid = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic          rd_wait;

   int errs = 0;
   int checks = 0;
   logic [31:0] mirror [DEPTH];
   logic [15:0] cfg_m = 16'hBD8B;

   always #2.5 clk = ~clk;

   burst_read_engine u_burst_read_engine (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .adr_valid(adr_valid), .addr(addr),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_wait(rd_wait)
   );

   function automatic logic [31:0] init_word(input int i);
      logic [31:0] p;
      p = 32'(i + 1) * 32'h9E3779B9;
      return p ^ 32'h5A5AC3C3;
   endfunction

   function automatic int m_len(input logic [15:0] c);
      case (c[2:0])
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 8;
         default: return 0;
      endcase
   endfunction

   function automatic bit m_burst(input logic [15:0] c);
      return !c[15] && c[7] && c[6] && m_len(c) != 0;
   endfunction

   function automatic int m_lat(input logic [15:0] c);
      return int'(c[12:10]) + 2;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic write_cfg(input logic [15:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      cfg_m = v;
   endtask

   task automatic write_mem(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      mem_we = 1'b1; mem_waddr = a; mem_wdata = d;
      @(negedge clk);
      mem_we = 1'b0;
      mirror[a] = d;
   endtask

   // Strobe address a; check cycles 1..stop (0 = full access plus one idle cycle).
   // At cycle wr_at (if nonzero) a configuration write of wr_val is driven.
   task automatic run_read(input logic [AW-1:0] a, input int stop_at,
                           input int wr_at, input logic [15:0] wr_val,
                           input string tag);
      logic [15:0] cap;
      bit b, early, ev, ew;
      int lat, len, total, stop;
      logic [31:0] ed;
      string dtag, wtag;
      cap   = cfg_m;
      b     = m_burst(cap);
      lat   = m_lat(cap);
      len   = m_len(cap);
      early = cap[8];
      total = b ? lat + len : 1;
      stop  = (stop_at == 0) ? total + 1 : stop_at;
      @(negedge clk);
      adr_valid = 1'b1; addr = a;
      @(negedge clk);
      adr_valid = 1'b0;
      for (int c = 1; c <= stop; c++) begin
         if (c == wr_at) begin
            cfg_we = 1'b1; cfg_wdata = wr_val; cfg_m = wr_val;
         end else begin
            cfg_we = 1'b0;
         end
         if (b) begin
            ew = early ? (c <= lat - 1) : (c <= lat);
            ev = (c >= lat + 1) && (c <= lat + len);
            ed = ev ? mirror[AW'(int'(a) + c - lat - 1)] : 32'h0;
            dtag = (tag != "") ? tag : ((c == lat + 1) ? "R3" : "R4");
            wtag = (tag != "") ? tag : (early ? "R7" : "R6");
         end else begin
            ew = 1'b0;
            ev = (c == 1);
            ed = ev ? mirror[a] : 32'h0;
            dtag = (tag != "") ? tag : "R5";
            wtag = (tag != "") ? tag : "R5";
         end
         chk(rd_valid == ev, dtag, "rd_valid", 32'(rd_valid), 32'(ev));
         chk(rd_data == ed, dtag, "rd_data", rd_data, ed);
         chk(rd_wait == ew, wtag, "rd_wait", 32'(rd_wait), 32'(ew));
         chk(!(rd_wait && rd_valid), "R9", "wait/valid overlap", 32'(rd_wait), 32'h0);
         if (c < stop) @(negedge clk);
      end
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [15:0] rc;
      logic [AW-1:0] ra;
      int st;
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) mirror[i] = init_word(i);

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!rd_valid, "R1", "rd_valid in reset", 32'(rd_valid), 32'h0);
      chk(!rd_wait, "R1", "rd_wait in reset", 32'(rd_wait), 32'h0);
      chk(rd_data == 0, "R1", "rd_data in reset", rd_data, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!rd_valid && !rd_wait, "R1", "idle after reset", {rd_valid, rd_wait}, 32'h0);
      run_read(6'd17, 0, 0, 16'h0, "R1");   // default register gives asynchronous read

      // R2: configuration write switches to a 3-clock, 4-word burst
      write_cfg(16'h04C2);
      run_read(6'd62, 0, 0, 16'h0, "R2");   // also wraps the address (R4)

      // R3 extremes of latency, with bit 13 set on the shortest, R7 early wait
      write_cfg(16'h20C1);  run_read(6'd3, 0, 0, 16'h0, "");
      write_cfg(16'h1CC3);  run_read(6'd59, 0, 0, 16'h0, "");
      write_cfg(16'h1DC3);  run_read(6'd20, 0, 0, 16'h0, "");
      write_cfg(16'h01C2);  run_read(6'd0, 0, 0, 16'h0, "");

      // R5: each reserved/asynchronous selection
      write_cfg(16'h1C43);  run_read(6'd9, 0, 0, 16'h0, "");
      write_cfg(16'h1C83);  run_read(6'd10, 0, 0, 16'h0, "");
      write_cfg(16'h1CC0);  run_read(6'd11, 0, 0, 16'h0, "");
      write_cfg(16'h1CC5);  run_read(6'd12, 0, 0, 16'h0, "");
      write_cfg(16'h9CC3);  run_read(6'd13, 0, 0, 16'h0, "");

      // R8: strobe in the middle of a burst
      write_cfg(16'h00C3);
      run_read(6'd10, 4, 0, 16'h0, "");
      run_read(6'd40, 0, 0, 16'h0, "R8");
      run_read(6'd50, 2, 0, 16'h0, "");      // abort during latency
      run_read(6'd30, 0, 0, 16'h0, "R8");

      // R10: configuration write mid-burst does not alter the access
      write_cfg(16'h08C3);
      run_read(6'd5, 0, 3, 16'hBD8B, "R10");
      run_read(6'd6, 0, 0, 16'h0, "R10");    // now asynchronous

      // R11: storage write visible in a burst
      write_mem(6'd7, 32'hDEADBEEF);
      write_cfg(16'h00C2);
      run_read(6'd6, 0, 0, 16'h0, "R11");

      // Random mix
      for (int n = 0; n < 220; n++) begin
         rc = 16'($urandom);
         if (($urandom % 4) != 0) begin
            rc[15] = 1'b0; rc[7] = 1'b1; rc[6] = 1'b1;
         end
         if (($urandom % 6) == 0) write_mem(AW'($urandom), $urandom);
         write_cfg(rc);
         ra = AW'($urandom);
         st = (($urandom % 4) == 0) ? 1 + int'($urandom % 10) : 0;
         run_read(ra, st, 0, 16'h0, "");
      end

      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule